// File: doc/BRIEF.md
# Coprocessor Doubleword Store Sequencer

This block executes one coprocessor store of a 64-bit value. It takes a 32-bit instruction word and decodes it under one of two encodings, chosen by a mode input. It reads the base general register through a combinational read port and adds the sign-extended offset to form the effective address. It then writes the doubleword to a 32-bit memory port as two word stores. The low word comes from the coprocessor register named by the instruction, and the high word from the next register up.

Under the legacy encoding the effective address must be doubleword aligned, and a misaligned address raises an address-error pulse with no write. Under the revised encoding a misaligned address is passed to memory unchanged. An instruction word that does not match the encoding for the current mode raises a reserved-instruction pulse and writes nothing.

Within each word store, the word placement follows the exclusive-OR of the CPU byte order and the reverse-endian control. When that value is 1, address bit 2 of the first store is inverted. The second store always goes to the first store's address with bit 2 inverted.

Top module: `cp_dword_store_seq`

## Requirements
- R1: With `enc_rev`=0, the instruction is legal when bits 31:26 are 111110. Bits 25:21 select the base register, bits 20:16 select rt, and bits 15:0 are a signed offset. The effective address is the base value plus the sign-extended offset.
- R2: With `enc_rev`=1, the instruction is legal when bits 31:26 are 010010 and bits 25:21 are 01111. Bits 20:16 select rt, bits 15:11 select the base register, and bits 10:0 are a signed offset added to the base value after sign extension.
- R3: With `enc_rev`=0, if effective address bits 2:0 are not zero, `addr_err` is high for exactly the one cycle after acceptance. In that case `st_valid` and `busy` stay low.
- R4: With `enc_rev`=1, a misaligned effective address raises no error. It is used in the stores as is.
- R5: An instruction that is not legal for the current mode makes `resv_instr` high for exactly the one cycle after acceptance. No store is issued and `busy` stays low.
- R6: The first store carries `cop_data` read at index rt. The second store carries the data read at index rt+1, taken modulo 32. The second address equals the first with bit 2 inverted.
- R7: The first store address is the effective address XOR (S << 2), where S = `big_end` XOR `rev_end`, sampled when the instruction is accepted.
- R8: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_addr` and `cop_idx` hold their values into the next cycle.
- R9: `busy` is high from the cycle after acceptance of a legal, non-faulting instruction. `done` is high for one cycle after the second store handshake, and in that cycle `busy` and `st_valid` are low.
- R10: `instr_valid` is taken only while idle. An instruction presented while `busy` is high is dropped and causes no store.
- R11: A synchronous active-high `rst` returns the block to idle. After it, `busy`, `st_valid`, `done`, `addr_err` and `resv_instr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_rev | input | 1 | Encoding select: 0 legacy, 1 revised |
| instr_valid | input | 1 | Instruction present; taken when idle |
| instr_word | input | 32 | Instruction word |
| busy | output | 1 | Store pair in progress |
| gpr_idx | output | 5 | Base register index decoded from `instr_word` |
| gpr_val | input | AW | Base register value for `gpr_idx` |
| big_end | input | 1 | CPU is big-endian |
| rev_end | input | 1 | Reverse-endian mode |
| cop_idx | output | 5 | Coprocessor register read index |
| cop_data | input | 32 | Coprocessor register value for `cop_idx` |
| st_valid | output | 1 | Word store request valid |
| st_ready | input | 1 | Memory accepts the word store |
| st_addr | output | AW | Word store address |
| st_data | output | 32 | Word store data |
| done | output | 1 | One-cycle pulse after the second store |
| addr_err | output | 1 | One-cycle misalignment error pulse |
| resv_instr | output | 1 | One-cycle illegal encoding pulse |

## Verification
An instruction is accepted at a rising edge. The `resv_instr` or `addr_err` pulse, or else the first store request with `busy`, is visible one edge later. The bench therefore drives at a falling edge, lets one rising edge pass, and samples at the next falling edge. A store handshake completes at the rising edge where `st_valid` and `st_ready` are both high. The second request, or after the second handshake the `done` pulse, is sampled at the following falling edge. Stalled cycles are compared against the values sampled half a cycle before the previous edge.

// File: rtl/dws_pkg.sv
package dws_pkg;

    localparam logic [5:0] LEG_MAJOR = 6'b111110;
    localparam logic [5:0] REV_MAJOR = 6'b010010;
    localparam logic [4:0] REV_MINOR = 5'b01111;
    localparam int         REG_IW    = 5;
    localparam int         OFS_W     = 16;
    localparam int         SWAP_BIT  = 2;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LO   = 2'd1,
        SQ_HI   = 2'd2
    } sq_state_t;

    typedef struct packed {
        logic                legal;
        logic [REG_IW-1:0]   rt;
        logic [REG_IW-1:0]   base;
        logic [OFS_W-1:0]    ofs;
    } dec_t;

    function automatic dec_t decode_insn(input logic rev, input logic [31:0] w);
        dec_t d;
        d = '0;
        if (!rev) begin
            d.legal = (w[31:26] == LEG_MAJOR);
            d.base  = w[25:21];
            d.rt    = w[20:16];
            d.ofs   = w[15:0];
        end else begin
            d.legal = (w[31:26] == REV_MAJOR) && (w[25:21] == REV_MINOR);
            d.rt    = w[20:16];
            d.base  = w[15:11];
            d.ofs   = {{(OFS_W-11){w[10]}}, w[10:0]};
        end
        return d;
    endfunction

endpackage

// File: rtl/dws_decode.sv
module dws_decode
    import dws_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              enc_rev,
    input  logic [31:0]       instr_word,
    input  logic [AW-1:0]     gpr_val,
    output logic [REG_IW-1:0] gpr_idx,
    output logic [REG_IW-1:0] rt,
    output logic              legal,
    output logic              fault,
    output logic [AW-1:0]     ea
);
    localparam int EXT_W = AW - OFS_W;

    dec_t dec;

    always_comb begin
        dec     = decode_insn(enc_rev, instr_word);
        gpr_idx = dec.base;
        rt      = dec.rt;
        legal   = dec.legal;
        ea      = gpr_val + {{EXT_W{dec.ofs[OFS_W-1]}}, dec.ofs};
        fault   = !enc_rev && (ea[2:0] != 3'b000);
    end
endmodule

// File: rtl/dws_issue.sv
module dws_issue
    import dws_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic              legal,
    input  logic              fault,
    input  logic [REG_IW-1:0] rt,
    input  logic [AW-1:0]     ea,
    input  logic              swap,
    input  logic              st_ready,
    output logic              busy,
    output logic              st_valid,
    output logic [AW-1:0]     st_addr,
    output logic [REG_IW-1:0] cop_idx,
    output logic              done,
    output logic              addr_err,
    output logic              resv_instr
);
    localparam logic [AW-1:0] WORD_FLIP = AW'(1) << SWAP_BIT;

    sq_state_t         state;
    logic [AW-1:0]     lo_addr;
    logic [REG_IW-1:0] rt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            lo_addr    <= '0;
            rt_q       <= '0;
            done       <= 1'b0;
            addr_err   <= 1'b0;
            resv_instr <= 1'b0;
        end else begin
            done       <= 1'b0;
            addr_err   <= 1'b0;
            resv_instr <= 1'b0;
            case (state)
                SQ_IDLE: if (instr_valid) begin
                    if (!legal) begin
                        resv_instr <= 1'b1;
                    end else if (fault) begin
                        addr_err <= 1'b1;
                    end else begin
                        state   <= SQ_LO;
                        lo_addr <= swap ? (ea ^ WORD_FLIP) : ea;
                        rt_q    <= rt;
                    end
                end
                SQ_LO: if (st_ready) state <= SQ_HI;
                SQ_HI: if (st_ready) begin
                    state <= SQ_IDLE;
                    done  <= 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state != SQ_IDLE);
        st_valid = busy;
        st_addr  = (state == SQ_HI) ? (lo_addr ^ WORD_FLIP) : lo_addr;
        cop_idx  = (state == SQ_HI) ? (rt_q + REG_IW'(1)) : rt_q;
    end

    // R8
    st_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(cop_idx)));

    // R6
    pair_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready && state == SQ_LO) |=>
            ((st_addr == ($past(st_addr) ^ WORD_FLIP)) &&
             (cop_idx == REG_IW'($past(cop_idx) + REG_IW'(1)))));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !st_valid) ##1 !done);

    // R3
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> (!st_valid && !resv_instr && !busy));

    // R5
    resv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        resv_instr |-> (!st_valid && !busy));
endmodule

// File: rtl/cp_dword_store_seq.sv
module cp_dword_store_seq
    import dws_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_rev,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              busy,
    output logic [4:0]        gpr_idx,
    input  logic [AW-1:0]     gpr_val,
    input  logic              big_end,
    input  logic              rev_end,
    output logic [4:0]        cop_idx,
    input  logic [31:0]       cop_data,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [AW-1:0]     st_addr,
    output logic [31:0]       st_data,
    output logic              done,
    output logic              addr_err,
    output logic              resv_instr
);
    logic [REG_IW-1:0] dec_rt;
    logic              dec_legal;
    logic              dec_fault;
    logic [AW-1:0]     dec_ea;

    dws_decode #(.AW(AW)) u_decode (
        .enc_rev    (enc_rev),
        .instr_word (instr_word),
        .gpr_val    (gpr_val),
        .gpr_idx    (gpr_idx),
        .rt         (dec_rt),
        .legal      (dec_legal),
        .fault      (dec_fault),
        .ea         (dec_ea)
    );

    dws_issue #(.AW(AW)) u_issue (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .legal       (dec_legal),
        .fault       (dec_fault),
        .rt          (dec_rt),
        .ea          (dec_ea),
        .swap        (big_end ^ rev_end),
        .st_ready    (st_ready),
        .busy        (busy),
        .st_valid    (st_valid),
        .st_addr     (st_addr),
        .cop_idx     (cop_idx),
        .done        (done),
        .addr_err    (addr_err),
        .resv_instr  (resv_instr)
    );

    assign st_data = cop_data;
endmodule

// File: tb/cp_dword_store_seq_test.sv
`timescale 1ns/1ps
module cp_dword_store_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_rev = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        busy;
    logic [4:0]  gpr_idx;
    logic [31:0] gpr_val;
    logic        big_end = 1'b0;
    logic        rev_end = 1'b0;
    logic [4:0]  cop_idx;
    logic [31:0] cop_data;
    logic        st_valid;
    logic        st_ready = 1'b0;
    logic [31:0] st_addr;
    logic [31:0] st_data;
    logic        done;
    logic        addr_err;
    logic        resv_instr;

    logic [31:0] gpr [32];
    logic [31:0] cop [32];
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    assign gpr_val  = gpr[gpr_idx];
    assign cop_data = cop[cop_idx];

    cp_dword_store_seq uut (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] leg_i(input int b, input int t, input logic [15:0] o);
        return {6'b111110, 5'(b), 5'(t), o};
    endfunction

    function automatic logic [31:0] rev_i(input int b, input int t, input logic [10:0] o);
        return {6'b010010, 5'b01111, 5'(t), 5'(b), o};
    endfunction

    function automatic bit is_legal(input bit rv, input logic [31:0] w);
        if (!rv) return w[31:26] == 6'b111110;
        return (w[31:26] == 6'b010010) && (w[25:21] == 5'b01111);
    endfunction

    function automatic logic [31:0] exp_ea(input bit rv, input logic [31:0] w);
        if (!rv) return gpr[w[25:21]] + {{16{w[15]}}, w[15:0]};
        return gpr[w[15:11]] + {{21{w[10]}}, w[10:0]};
    endfunction

    task automatic run_one(input bit rv, input logic [31:0] w, input bit be, input bit re,
                           input int stall_pct, input bit intrude);
        logic [31:0] ea, lo, a_prev, d_prev;
        logic [4:0]  rt;
        bit          mis;
        string       tag;
        rt  = w[20:16];
        ea  = exp_ea(rv, w);
        lo  = ea ^ {29'd0, be ^ re, 2'b00};
        mis = (ea[2:0] != 3'b000);
        tag = rv ? (mis ? "R2 R4 R6 R7" : "R2 R6 R7") : "R1 R6 R7";
        @(negedge clk);
        enc_rev = rv; instr_word = w; big_end = be; rev_end = re; instr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        if (!is_legal(rv, w)) begin
            chk(resv_instr == 1'b1, "R5 resv pulse", 32'(resv_instr), 32'd1);
            chk(!st_valid && !busy && !addr_err, "R5 no store", {st_valid, busy, addr_err}, 32'd0);
            @(negedge clk);
            chk(!resv_instr && !st_valid, "R5 pulse ends", {resv_instr, st_valid}, 32'd0);
            return;
        end
        if (!rv && mis) begin
            chk(addr_err == 1'b1, "R3 addr_err pulse", 32'(addr_err), 32'd1);
            chk(!st_valid && !busy, "R3 no store", {st_valid, busy}, 32'd0);
            @(negedge clk);
            chk(!addr_err && !st_valid, "R3 pulse ends", {addr_err, st_valid}, 32'd0);
            return;
        end
        chk(busy && !addr_err, "R9 R4 busy after accept", {busy, addr_err}, 32'd2);
        for (int k = 0; k < 2; k++) begin
            logic [31:0] ea_k, d_k;
            ea_k = (k == 0) ? lo : (lo ^ 32'd4);
            d_k  = (k == 0) ? cop[rt] : cop[5'(rt + 5'd1)];
            forever begin
                bit rdy;
                chk(st_valid == 1'b1, "R8 valid held", 32'(st_valid), 32'd1);
                if (intrude) begin
                    instr_valid = 1'b1;
                    instr_word  = leg_i(3, 4, 16'h0000);
                    enc_rev     = 1'b0;
                end
                rdy = (int'($urandom % 100) >= stall_pct);
                st_ready = rdy;
                if (rdy) begin
                    chk(st_addr == ea_k, {tag, " address"}, st_addr, ea_k);
                    chk(st_data == d_k, "R6 data word", st_data, d_k);
                    @(posedge clk);
                    @(negedge clk);
                    break;
                end
                a_prev = st_addr; d_prev = st_data;
                @(posedge clk);
                @(negedge clk);
                chk(st_addr == a_prev && st_data == d_prev, "R8 stall hold", st_addr, a_prev);
            end
        end
        st_ready = 1'b0;
        instr_valid = 1'b0;
        chk(done && !busy && !st_valid, "R9 done pulse", {done, busy, st_valid}, 32'h4);
        @(negedge clk);
        chk(!done, "R9 done single", 32'(done), 32'd0);
        chk(!st_valid && !busy, "R10 dropped while busy", {st_valid, busy}, 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) begin
            gpr[i] = $urandom;
            if (i % 2 == 0) gpr[i][2:0] = 3'b000;
            cop[i] = $urandom;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !st_valid && !done && !addr_err && !resv_instr, "R11 reset state",
            {busy, st_valid, done, addr_err, resv_instr}, 32'd0);
        rst = 1'b0;

        // directed corners
        run_one(1'b0, leg_i(2, 5, 16'h0010), 1'b0, 1'b0, 0, 1'b0);   // R1 aligned
        run_one(1'b0, leg_i(2, 5, 16'hFFF8), 1'b1, 1'b0, 50, 1'b0);  // R1 negative ofs, R7
        run_one(1'b0, leg_i(2, 6, 16'h0004), 1'b0, 1'b0, 0, 1'b0);   // R3 misaligned
        run_one(1'b1, rev_i(4, 7, 11'h7FC), 1'b0, 1'b1, 30, 1'b0);   // R2 R4 misaligned passes
        run_one(1'b1, rev_i(4, 31, 11'h008), 1'b1, 1'b1, 0, 1'b0);   // R6 rt wrap
        run_one(1'b1, leg_i(2, 5, 16'h0010), 1'b0, 0, 0, 1'b0);      // R5 legacy in revised mode
        run_one(1'b1, {6'b010010, 5'b01110, 21'd0}, 1'b0, 0, 0, 1'b0); // R5 bad minor field
        run_one(1'b0, rev_i(4, 7, 11'h008), 1'b0, 0, 0, 1'b0);       // R5 revised in legacy mode
        run_one(1'b0, leg_i(0, 9, 16'h0020), 1'b1, 1'b1, 60, 1'b1);  // R10 intrusion while busy

        // R11 reset mid-sequence
        @(negedge clk);
        enc_rev = 1'b0; instr_word = leg_i(2, 1, 16'h0000); instr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0; st_ready = 1'b0; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(!busy && !st_valid && !done, "R11 reset mid pair", {busy, st_valid, done}, 32'd0);

        // constrained random
        for (int n = 0; n < 300; n++) begin
            bit rv;
            int sel;
            logic [31:0] w;
            logic [15:0] o;
            rv  = $urandom % 2;
            sel = $urandom % 10;
            o   = 16'($urandom);
            if ($urandom % 10 < 7) o[2:0] = 3'b000;
            if (sel < 4)      w = leg_i($urandom % 32, $urandom % 32, o);
            else if (sel < 8) w = rev_i($urandom % 32, $urandom % 32, o[10:0]);
            else              w = $urandom;
            run_one(rv, w, $urandom % 2, $urandom % 2, $urandom % 60, ($urandom % 4) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule